// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block holds the bypass-select and stall/flush decision logic for a five-stage load/store pipeline (fetch, decode, execute, memory, writeback). For each of the two ALU source operands of the instruction in execute, it compares the operand's register number with the destinations of the two older instructions still in flight. It then reports the source the operand mux should use: the register file, the ALU result held after execute, the ALU result held after memory, or the load data held after memory. When two older instructions write the same register, the younger one always wins.

The block also handles two pipeline events. A store whose data register is written by the load just ahead of it takes its data from the memory read output, with no stall. A load whose result is needed at once by the next instruction's ALU stage holds fetch and decode for one cycle and sends a bubble into execute. A taken branch, resolved in execute, squashes the two younger instructions behind it. That squash takes priority over any stall in the same cycle. All decisions are combinational. The clock and reset serve only the built-in property checks.

Top module: `fwd_hazard_unit`

## Requirements
- R1: The operand select encoding is 0 = register file, 1 = post-execute ALU result, 2 = post-memory ALU result, 3 = post-memory load data. An operand whose register matches a writing, non-load post-execute instruction selects 1.
- R2: When both the post-execute and the post-memory instruction write the operand's register, the select is 1, because the younger writer wins.
- R3: When only the post-memory instruction writes the operand's register, the select is 3 if that instruction is a load and 2 otherwise.
- R4: The two operand selects are decided independently. Both may be non-zero in the same cycle, from the same latch or from different latches.
- R5: Register 0 never produces a forward, a stall, or a store-data forward, even when a producer names it as its destination.
- R6: A producer whose write enable is low never causes a forward or a stall. A lower-priority writer that is enabled is then used.
- R7: An operand that matches no in-flight destination selects 0, the register-file value, which already holds writes made three or more slots earlier.
- R8: When the execute stage holds an enabled load to a non-zero register, and the decode-stage instruction reads that register as a first operand, or as a second operand while not being a store, then pc_hold, ifid_hold and idex_bubble all go high.
- R9: A decode-stage store whose data register is the loaded register does not stall. When that store reaches memory with the load just ahead of it, st_data_fwd is 1. st_data_fwd is 0 if the older instruction is not a load.
- R10: branch_taken raises ifid_flush and idex_flush together, and it forces pc_hold, ifid_hold and idex_bubble low in that cycle.
- R11: A load in the post-execute latch is never selected as source 1. The operand falls through to the post-memory source or to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Asynchronous active-low reset for the property checks |
| ifid_rs1 | input | RW | Decode-stage first source register |
| ifid_rs2 | input | RW | Decode-stage second source register |
| ifid_is_store | input | 1 | Decode-stage instruction is a store |
| idex_rs1 | input | RW | Execute-stage first source register |
| idex_rs2 | input | RW | Execute-stage second source register |
| idex_rd | input | RW | Execute-stage destination register |
| idex_we | input | 1 | Execute-stage register write enable |
| idex_is_load | input | 1 | Execute-stage instruction is a load |
| exm_rd | input | RW | Post-execute latch destination register |
| exm_we | input | 1 | Post-execute latch write enable |
| exm_is_load | input | 1 | Post-execute latch holds a load |
| exm_is_store | input | 1 | Post-execute latch holds a store |
| exm_rs2 | input | RW | Data register of the store in the post-execute latch |
| mwb_rd | input | RW | Post-memory latch destination register |
| mwb_we | input | 1 | Post-memory latch write enable |
| mwb_is_load | input | 1 | Post-memory latch holds a load |
| branch_taken | input | 1 | Branch in execute resolved taken |
| fwd_a_sel | output | 2 | First ALU operand source select |
| fwd_b_sel | output | 2 | Second ALU operand source select |
| st_data_fwd | output | 1 | Store data taken from the memory read output |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the fetch/decode latch |
| idex_bubble | output | 1 | Load a bubble into the decode/execute latch |
| ifid_flush | output | 1 | Squash the fetch/decode latch |
| idex_flush | output | 1 | Squash the decode/execute latch |

## Verification
The properties check on every cycle that register 0 and disabled writers never forward, and that a post-execute load is never chosen as a source. They also check that a stall always traces back to an enabled load in execute, that a taken branch flushes both latches and suppresses the stall, and that store-data forwarding occurs only behind a load. Only the bench scenarios show the exact select value for each overlap pattern. These include the younger writer winning over an older one and both operands fed from one latch. The scenarios also cover the split between a store that uses the loaded value as its address, which stalls, and one that uses it as its data, which does not.

// File: rtl/fhu_pkg.sv
package fhu_pkg;
  typedef enum logic [1:0] {
    SRC_RF       = 2'd0,
    SRC_EXM_ALU  = 2'd1,
    SRC_MWB_ALU  = 2'd2,
    SRC_MWB_LOAD = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/operand_fwd_sel.sv
module operand_fwd_sel
  import fhu_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src_reg,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_is_load,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_we,
  input  logic          mwb_is_load,
  output fwd_src_e      sel
);
  logic src_live;
  logic hit_exm;
  logic hit_mwb;

  always_comb begin
    src_live = (src_reg != '0);
    hit_exm  = src_live && exm_we && !exm_is_load && (exm_rd == src_reg);
    hit_mwb  = src_live && mwb_we && (mwb_rd == src_reg);
    // youngest writer first
    if (hit_exm)
      sel = SRC_EXM_ALU;
    else if (hit_mwb)
      sel = mwb_is_load ? SRC_MWB_LOAD : SRC_MWB_ALU;
    else
      sel = SRC_RF;
  end
endmodule

// File: rtl/loaduse_ctrl.sv
module loaduse_ctrl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ifid_rs1,
  input  logic [RW-1:0] ifid_rs2,
  input  logic          ifid_is_store,
  input  logic [RW-1:0] idex_rd,
  input  logic          idex_we,
  input  logic          idex_is_load,
  input  logic          branch_taken,
  output logic          stall,
  output logic          flush
);
  logic ld_live;
  logic use_a;
  logic use_b;

  always_comb begin
    ld_live = idex_is_load && idex_we && (idex_rd != '0);
    use_a   = (ifid_rs1 == idex_rd);
    // a store's data operand is served from memory output, no stall
    use_b   = (ifid_rs2 == idex_rd) && !ifid_is_store;
    flush   = branch_taken;
    stall   = ld_live && (use_a || use_b) && !branch_taken;
  end
endmodule

// File: rtl/store_data_fwd.sv
module store_data_fwd #(
  parameter int RW = 5
) (
  input  logic          exm_is_store,
  input  logic [RW-1:0] exm_rs2,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_we,
  input  logic          mwb_is_load,
  output logic          sd_fwd
);
  always_comb begin
    sd_fwd = exm_is_store && mwb_is_load && mwb_we &&
             (mwb_rd != '0) && (mwb_rd == exm_rs2);
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fhu_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ifid_rs1,
  input  logic [RW-1:0] ifid_rs2,
  input  logic          ifid_is_store,
  input  logic [RW-1:0] idex_rs1,
  input  logic [RW-1:0] idex_rs2,
  input  logic [RW-1:0] idex_rd,
  input  logic          idex_we,
  input  logic          idex_is_load,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_is_load,
  input  logic          exm_is_store,
  input  logic [RW-1:0] exm_rs2,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_we,
  input  logic          mwb_is_load,
  input  logic          branch_taken,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          st_data_fwd,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush,
  output logic          idex_flush
);
  localparam int NOPS = 2;

  logic [RW-1:0] op_reg [NOPS];
  fwd_src_e      op_sel [NOPS];
  logic          stall;
  logic          flush;

  assign op_reg[0] = idex_rs1;
  assign op_reg[1] = idex_rs2;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    operand_fwd_sel #(.RW(RW)) u_sel (
      .src_reg     (op_reg[g]),
      .exm_rd      (exm_rd),
      .exm_we      (exm_we),
      .exm_is_load (exm_is_load),
      .mwb_rd      (mwb_rd),
      .mwb_we      (mwb_we),
      .mwb_is_load (mwb_is_load),
      .sel         (op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  loaduse_ctrl #(.RW(RW)) u_hz (
    .ifid_rs1      (ifid_rs1),
    .ifid_rs2      (ifid_rs2),
    .ifid_is_store (ifid_is_store),
    .idex_rd       (idex_rd),
    .idex_we       (idex_we),
    .idex_is_load  (idex_is_load),
    .branch_taken  (branch_taken),
    .stall         (stall),
    .flush         (flush)
  );

  store_data_fwd #(.RW(RW)) u_sd (
    .exm_is_store (exm_is_store),
    .exm_rs2      (exm_rs2),
    .mwb_rd       (mwb_rd),
    .mwb_we       (mwb_we),
    .mwb_is_load  (mwb_is_load),
    .sd_fwd       (st_data_fwd)
  );

  always_comb begin
    pc_hold     = stall;
    ifid_hold   = stall;
    idex_bubble = stall;
    ifid_flush  = flush;
    idex_flush  = flush;
  end

  AST_YOUNG_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rs1 != '0 && exm_we && !exm_is_load && exm_rd == idex_rs1)
      |-> fwd_a_sel == 2'd1); // R2
  AST_X0_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rs1 == '0) |-> (fwd_a_sel == 2'd0)); // R5
  AST_NO_WE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exm_we && !mwb_we) |-> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0)); // R6
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (idex_is_load && idex_we && idex_rd != '0)); // R8
  AST_SD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st_data_fwd |-> (mwb_is_load && mwb_we && exm_is_store)); // R9
  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> (ifid_flush && idex_flush && !pc_hold && !idex_bubble)); // R10
  AST_EXM_LOAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    exm_is_load |-> (fwd_a_sel != 2'd1 && fwd_b_sel != 2'd1)); // R11
endmodule

// File: tb/tb_fwd_hazard_unit.sv
`timescale 1ns/1ps
module tb_fwd_hazard_unit;
  localparam int RW = 5;

  typedef struct packed {
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic [RW-1:0] xrd;
    logic          xwe;
    logic          xld;
    logic [RW-1:0] mrd;
    logic          mwe;
    logic          mld;
    logic [1:0]    ea;
    logic [1:0]    eb;
  } fvec_t;

  localparam int NV = 11;
  localparam fvec_t FV [NV] = '{
    '{5'd1,  5'd2,  5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'd1, 2'd0}, // R1
    '{5'd3,  5'd4,  5'd5,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'd0, 2'd2}, // R3
    '{5'd1,  5'd1,  5'd1,  1'b1, 1'b0, 5'd1,  1'b1, 1'b0, 2'd1, 2'd1}, // R2
    '{5'd6,  5'd7,  5'd7,  1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 2'd3, 2'd1}, // R4
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 1'b1, 2'd0, 2'd0}, // R5
    '{5'd8,  5'd8,  5'd8,  1'b0, 1'b0, 5'd8,  1'b0, 1'b0, 2'd0, 2'd0}, // R6
    '{5'd9,  5'd10, 5'd9,  1'b1, 1'b1, 5'd9,  1'b1, 1'b0, 2'd2, 2'd0}, // R11
    '{5'd12, 5'd12, 5'd11, 1'b1, 1'b0, 5'd12, 1'b1, 1'b1, 2'd3, 2'd3}, // R4
    '{5'd13, 5'd14, 5'd15, 1'b1, 1'b0, 5'd16, 1'b1, 1'b0, 2'd0, 2'd0}, // R7
    '{5'd8,  5'd3,  5'd8,  1'b0, 1'b0, 5'd8,  1'b1, 1'b0, 2'd2, 2'd0}, // R6
    '{5'd31, 5'd2,  5'd31, 1'b1, 1'b0, 5'd2,  1'b1, 1'b1, 2'd1, 2'd3}  // R4
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [RW-1:0] ifid_rs1, ifid_rs2, idex_rs1, idex_rs2, idex_rd;
  logic [RW-1:0] exm_rd, exm_rs2, mwb_rd;
  logic ifid_is_store, idex_we, idex_is_load, exm_we, exm_is_load;
  logic exm_is_store, mwb_we, mwb_is_load, branch_taken;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic st_data_fwd, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fwd_hazard_unit #(.RW(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ifid_rs1(ifid_rs1), .ifid_rs2(ifid_rs2), .ifid_is_store(ifid_is_store),
    .idex_rs1(idex_rs1), .idex_rs2(idex_rs2), .idex_rd(idex_rd),
    .idex_we(idex_we), .idex_is_load(idex_is_load),
    .exm_rd(exm_rd), .exm_we(exm_we), .exm_is_load(exm_is_load),
    .exm_is_store(exm_is_store), .exm_rs2(exm_rs2),
    .mwb_rd(mwb_rd), .mwb_we(mwb_we), .mwb_is_load(mwb_is_load),
    .branch_taken(branch_taken),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .st_data_fwd(st_data_fwd),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .idex_flush(idex_flush)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ifid_rs1 = '0; ifid_rs2 = '0; ifid_is_store = 1'b0;
    idex_rs1 = '0; idex_rs2 = '0; idex_rd = '0; idex_we = 1'b0; idex_is_load = 1'b0;
    exm_rd = '0; exm_we = 1'b0; exm_is_load = 1'b0; exm_is_store = 1'b0; exm_rs2 = '0;
    mwb_rd = '0; mwb_we = 1'b0; mwb_is_load = 1'b0; branch_taken = 1'b0;
  endtask

  // {pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush}
  function automatic logic [7:0] ctl();
    return {3'b0, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush};
  endfunction

  task automatic hz(input logic [RW-1:0] r1, input logic [RW-1:0] r2, input logic st,
                    input logic [RW-1:0] rd, input logic we, input logic ld, input logic br);
    @(negedge clk);
    idle();
    ifid_rs1 = r1; ifid_rs2 = r2; ifid_is_store = st;
    idex_rd = rd; idex_we = we; idex_is_load = ld; branch_taken = br;
    #1;
  endtask

  task automatic sd(input logic st, input logic [RW-1:0] r2, input logic [RW-1:0] rd,
                    input logic we, input logic ld);
    @(negedge clk);
    idle();
    exm_is_store = st; exm_rs2 = r2; mwb_rd = rd; mwb_we = we; mwb_is_load = ld;
    #1;
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset sel", {4'b0, fwd_a_sel, fwd_b_sel}, 8'h00);
    chk("R8 reset ctl", ctl(), 8'h00);
    chk("R9 reset sd", {7'b0, st_data_fwd}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      idex_rs1 = FV[i].rs1; idex_rs2 = FV[i].rs2;
      exm_rd = FV[i].xrd; exm_we = FV[i].xwe; exm_is_load = FV[i].xld;
      mwb_rd = FV[i].mrd; mwb_we = FV[i].mwe; mwb_is_load = FV[i].mld;
      #1;
      chk($sformatf("R1-table vec%0d sel", i), {4'b0, fwd_a_sel, fwd_b_sel},
          {4'b0, FV[i].ea, FV[i].eb});
    end

    hz(5'd5, 5'd0, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0);
    chk("R8 load-use rs1", ctl(), 8'b000_11100);
    hz(5'd0, 5'd5, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0);
    chk("R8 load-use rs2", ctl(), 8'b000_11100);
    hz(5'd3, 5'd5, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0);
    chk("R9 store data no stall", ctl(), 8'h00);
    hz(5'd5, 5'd3, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0);
    chk("R8 store address stalls", ctl(), 8'b000_11100);
    hz(5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0);
    chk("R8 alu producer no stall", ctl(), 8'h00);
    hz(5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0);
    chk("R5 x0 load no stall", ctl(), 8'h00);
    hz(5'd6, 5'd6, 1'b0, 5'd6, 1'b0, 1'b1, 1'b0);
    chk("R6 disabled load no stall", ctl(), 8'h00);
    hz(5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 1'b1, 1'b1);
    chk("R10 flush beats stall", ctl(), 8'b000_00011);
    hz(5'd1, 5'd2, 1'b0, 5'd9, 1'b1, 1'b0, 1'b1);
    chk("R10 plain flush", ctl(), 8'b000_00011);

    sd(1'b1, 5'd5, 5'd5, 1'b1, 1'b1);
    chk("R9 mem-to-mem fwd", {7'b0, st_data_fwd}, 8'h01);
    sd(1'b1, 5'd5, 5'd5, 1'b1, 1'b0);
    chk("R9 alu older no sd", {7'b0, st_data_fwd}, 8'h00);
    sd(1'b1, 5'd0, 5'd0, 1'b1, 1'b1);
    chk("R5 x0 no sd", {7'b0, st_data_fwd}, 8'h00);
    sd(1'b0, 5'd5, 5'd5, 1'b1, 1'b1);
    chk("R9 non-store no sd", {7'b0, st_data_fwd}, 8'h00);
    sd(1'b1, 5'd5, 5'd5, 1'b0, 1'b1);
    chk("R6 disabled load no sd", {7'b0, st_data_fwd}, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule